// File: doc/BRIEF.md
# Locked Redundant-Encoding Enable Controls

This block is the small control-register slice of a security peripheral. It stores two 4-bit enable fields, each in its own register. The module enable switches the peripheral on. The strict-mode enable marks that the high-assurance health thresholds are in force.

Each field uses a redundant 4-bit encoding. Only one value counts as "on", and only two values are legal. Any other value raises a sticky recoverable alert. Each enable register has its own write lock. Software can clear a lock but can never set it again.

The block produces three outputs from its state:
- `qual_out`, the outgoing quality flag, which is the incoming quality flag masked by the strict-mode enable.
- `seed_load`, a one-cycle pulse raised when the module becomes enabled.
- `mod_en` and `strict_en`, the two decoded enables, exposed for the rest of the peripheral.

Software reaches the registers through a single-cycle write strobe with a byte address and a combinational read port.

Top module: `enctl_top`

## Requirements
- R1: After reset both lock registers read 1, both enable registers read 0x5, the alert register reads 0, and `mod_en`, `strict_en`, `seed_load` and `qual_out` are 0.
- R2: The module-enable register is at address 0x08, in bits 3:0. `mod_en` is 1 only while that field holds exactly 0xA. Any other value, including the legal "off" value 0x5, gives 0.
- R3: The configuration register is at address 0x0C, holding the strict-mode enable in bits 3:0. `strict_en` is 1 only for 0xA. `qual_out` equals `qual_in` AND `strict_en`.
- R4: The module lock is at 0x00 and the general lock at 0x04, each in bit 0. Writing 0 clears a lock. Writing 1 has no effect, so a cleared lock stays 0 until reset.
- R5: While the module lock reads 0, writes to 0x08 are ignored. Writes to 0x0C are not affected by the module lock.
- R6: While the general lock reads 0, writes to 0x0C are ignored. Writes to 0x08 are not affected by the general lock.
- R7: In the alert register at 0x10, bit 2 becomes 1 on the clock edge after the module-enable field holds a value other than 0x5 or 0xA. The bit stays set after the field becomes legal again.
- R8: In the alert register, bit 0 becomes 1 on the clock edge after the strict-mode field holds a value other than 0x5 or 0xA. The bit is sticky.
- R9: Writing 0 to an alert bit clears it, and writing 1 leaves it unchanged. If the hardware sets a bit and software clears it in the same cycle, the bit ends up set.
- R10: `seed_load` is 1 for exactly one cycle, the cycle after the write that turns `mod_en` from 0 to 1. It stays 0 while `mod_en` remains 1, and pulses again on a later 0-to-1 transition.
- R11: Unimplemented register bits read 0. This covers bits 31:4 of both enable registers, bits 31:1 of the lock registers, and bit 1 and bits 31:3 of the alert register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 5 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Byte address of the read |
| rd_data | output | 32 | Combinational read data |
| qual_in | input | 1 | Internal quality flag of delivered data |
| qual_out | output | 1 | Quality flag masked by the strict-mode enable |
| mod_en | output | 1 | Strict-true decode of the module enable |
| strict_en | output | 1 | Strict-true decode of the strict-mode enable |
| seed_load | output | 1 | One-cycle pulse on the module enable's rising edge |

## Verification
The hardest case to reach is a hardware set and a software clear of the same alert bit on the same clock edge. The stimulus writes an illegal module-enable value and then, on the very next edge, writes 0 to the alert register. At that edge the illegal field is still driving the set, so the bit must read back as 1. The bench then restores a legal value and shows that the same clear now takes effect.

The lock cases are reached the same way. Once a lock is cleared it cannot be reopened, so those checks run last in the sequence. Before them, the bench shows that the other register still accepts writes.

// File: rtl/enctl_pkg.sv
package enctl_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    localparam int EN_W   = 4;

    typedef enum logic [EN_W-1:0] {
        EN_OFF = 4'h5,
        EN_ON  = 4'hA
    } en_code_e;

    localparam logic [ADDR_W-1:0] A_MOD_LOCK = 5'h00;
    localparam logic [ADDR_W-1:0] A_GEN_LOCK = 5'h04;
    localparam logic [ADDR_W-1:0] A_MOD_EN   = 5'h08;
    localparam logic [ADDR_W-1:0] A_CONF     = 5'h0C;
    localparam logic [ADDR_W-1:0] A_ALERT    = 5'h10;

    localparam int ALERT_STRICT_BIT = 0;
    localparam int ALERT_MOD_BIT    = 2;
    localparam int ALERT_W          = 3;

    function automatic logic en_is_on(input logic [EN_W-1:0] v);
        return v == EN_ON;
    endfunction

    function automatic logic en_is_bad(input logic [EN_W-1:0] v);
        return (v != EN_ON) && (v != EN_OFF);
    endfunction
endpackage

// File: rtl/enctl_lock.sv
module enctl_lock (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic wbit,
    output logic open
);
    // Clear-only: a write of 0 closes the lock; nothing reopens it but reset.
    always_ff @(posedge clk) begin
        if (rst)
            open <= 1'b1;
        else if (wr && !wbit)
            open <= 1'b0;
    end
endmodule

// File: rtl/enctl_field.sv
module enctl_field
    import enctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic            open,
    input  logic [EN_W-1:0] wdata,
    output logic [EN_W-1:0] value,
    output logic            is_on,
    output logic            is_bad
);
    always_ff @(posedge clk) begin
        if (rst)
            value <= EN_OFF;
        else if (wr && open)
            value <= wdata;
    end

    assign is_on  = en_is_on(value);
    assign is_bad = en_is_bad(value);
endmodule

// File: rtl/enctl_alert.sv
module enctl_alert
    import enctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [ALERT_W-1:0] wbits,
    input  logic [ALERT_W-1:0] hw_set,
    output logic [ALERT_W-1:0] sts
);
    localparam logic [ALERT_W-1:0] IMPL =
        ALERT_W'((1 << ALERT_STRICT_BIT) | (1 << ALERT_MOD_BIT));

    for (genvar i = 0; i < ALERT_W; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            always_ff @(posedge clk) begin
                if (rst)
                    sts[i] <= 1'b0;
                else if (hw_set[i])
                    sts[i] <= 1'b1;
                else if (wr && !wbits[i])
                    sts[i] <= 1'b0;
            end
        end else begin : g_rsvd
            assign sts[i] = 1'b0;
        end
    end
endmodule

// File: rtl/enctl_top.sv
module enctl_top
    import enctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              qual_in,
    output logic              qual_out,
    output logic              mod_en,
    output logic              strict_en,
    output logic              seed_load
);
    logic            mod_open, gen_open;
    logic [EN_W-1:0] mod_field, cfg_field;
    logic            mod_bad, cfg_bad;
    logic [ALERT_W-1:0] alert_sts, alert_set;
    logic            mod_en_q;

    enctl_lock u_mod_lock (
        .clk(clk), .rst(rst),
        .wr(wr_en && wr_addr == A_MOD_LOCK),
        .wbit(wr_data[0]), .open(mod_open)
    );

    enctl_lock u_gen_lock (
        .clk(clk), .rst(rst),
        .wr(wr_en && wr_addr == A_GEN_LOCK),
        .wbit(wr_data[0]), .open(gen_open)
    );

    enctl_field u_mod_field (
        .clk(clk), .rst(rst),
        .wr(wr_en && wr_addr == A_MOD_EN), .open(mod_open),
        .wdata(wr_data[EN_W-1:0]),
        .value(mod_field), .is_on(mod_en), .is_bad(mod_bad)
    );

    enctl_field u_cfg_field (
        .clk(clk), .rst(rst),
        .wr(wr_en && wr_addr == A_CONF), .open(gen_open),
        .wdata(wr_data[EN_W-1:0]),
        .value(cfg_field), .is_on(strict_en), .is_bad(cfg_bad)
    );

    always_comb begin
        alert_set = '0;
        alert_set[ALERT_STRICT_BIT] = cfg_bad;
        alert_set[ALERT_MOD_BIT]    = mod_bad;
    end

    enctl_alert u_alert (
        .clk(clk), .rst(rst),
        .wr(wr_en && wr_addr == A_ALERT),
        .wbits(wr_data[ALERT_W-1:0]),
        .hw_set(alert_set), .sts(alert_sts)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mod_en_q <= 1'b0;
        else
            mod_en_q <= mod_en;
    end

    assign seed_load = mod_en && !mod_en_q;
    assign qual_out  = qual_in && strict_en;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_MOD_LOCK: rd_data[0]        = mod_open;
            A_GEN_LOCK: rd_data[0]        = gen_open;
            A_MOD_EN:   rd_data[EN_W-1:0] = mod_field;
            A_CONF:     rd_data[EN_W-1:0] = cfg_field;
            A_ALERT:    rd_data[ALERT_W-1:0] = alert_sts;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/enctl_chk.sv
module enctl_chk
    import enctl_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               mod_open,
    input logic               gen_open,
    input logic [EN_W-1:0]    mod_field,
    input logic [EN_W-1:0]    cfg_field,
    input logic [ALERT_W-1:0] alert_sts,
    input logic               mod_en,
    input logic               strict_en,
    input logic               qual_out,
    input logic               seed_load
);
    // R4
    mod_lock_stays_shut_chk: assert property (@(posedge clk) disable iff (rst)
        !mod_open |=> !mod_open);
    // R4
    gen_lock_stays_shut_chk: assert property (@(posedge clk) disable iff (rst)
        !gen_open |=> !gen_open);
    // R5
    mod_field_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !mod_open |=> $stable(mod_field));
    // R6
    cfg_field_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !gen_open |=> $stable(cfg_field));
    // R7
    mod_alert_set_chk: assert property (@(posedge clk) disable iff (rst)
        (mod_field != 4'h5 && mod_field != 4'hA) |=> alert_sts[2]);
    // R8
    cfg_alert_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_field != 4'h5 && cfg_field != 4'hA) |=> alert_sts[0]);
    // R3
    qual_gated_chk: assert property (@(posedge clk) disable iff (rst)
        qual_out |-> (cfg_field == 4'hA && strict_en));
    // R10
    seed_single_chk: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> !seed_load);
    // R10
    seed_on_enable_chk: assert property (@(posedge clk) disable iff (rst)
        seed_load |-> (mod_en && mod_field == 4'hA));
    // R11
    alert_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        !alert_sts[1]);
endmodule

bind enctl_top enctl_chk u_chk (
    .clk(clk), .rst(rst),
    .mod_open(mod_open), .gen_open(gen_open),
    .mod_field(mod_field), .cfg_field(cfg_field),
    .alert_sts(alert_sts), .mod_en(mod_en), .strict_en(strict_en),
    .qual_out(qual_out), .seed_load(seed_load)
);

// File: tb/test_enctl_top.sv
module test_enctl_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        qual_in = 1'b0;
    logic        qual_out, mod_en, strict_en, seed_load;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    enctl_top i_enctl_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .qual_in(qual_in), .qual_out(qual_out), .mod_en(mod_en),
        .strict_en(strict_en), .seed_load(seed_load)
    );

    typedef struct packed {
        logic [4:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic        exp_mod;
        logic        exp_strict;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{5'h08, 32'h0000_000A, 32'h0000_000A, 1'b1, 1'b0},
        '{5'h0C, 32'h0000_000A, 32'h0000_000A, 1'b1, 1'b1},
        '{5'h08, 32'h0000_0005, 32'h0000_0005, 1'b0, 1'b1},
        '{5'h08, 32'h0000_0003, 32'h0000_0003, 1'b0, 1'b1},
        '{5'h0C, 32'hFFFF_FF0A, 32'h0000_000A, 1'b0, 1'b1},
        '{5'h0C, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
        '{5'h0C, 32'h0000_0005, 32'h0000_0005, 1'b0, 1'b0},
        '{5'h08, 32'hABCD_0005, 32'h0000_0005, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; returns at the next falling edge, one edge after the write.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(5'h00, d); check("R1 mod lock", d, 32'h1);
        rd(5'h04, d); check("R1 gen lock", d, 32'h1);
        rd(5'h08, d); check("R1 mod enable", d, 32'h5);
        rd(5'h0C, d); check("R1 conf", d, 32'h5);
        rd(5'h10, d); check("R1 alert", d, 32'h0);
        check("R1 outputs", {28'h0, mod_en, strict_en, seed_load, qual_out}, 32'h0);

        // R2 R3 R11 table walk
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].addr, VECS[i].wdata);
            rd(VECS[i].addr, d);
            check("R11 readback", d, VECS[i].exp_rd);
            check("R2 mod_en", {31'h0, mod_en}, {31'h0, VECS[i].exp_mod});
            check("R3 strict_en", {31'h0, strict_en}, {31'h0, VECS[i].exp_strict});
        end

        // R7 R8 both alerts sticky after illegal values were removed
        rd(5'h10, d); check("R7 R8 sticky alerts", d, 32'h5);
        // R9 write of ones leaves them
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h10, d); check("R9 write ones", d, 32'h5);
        wr(5'h10, 32'h0);
        rd(5'h10, d); check("R9 clear", d, 32'h0);

        // R9 hardware set wins over same-edge clear
        wr(5'h08, 32'hC);
        wr(5'h10, 32'h0);
        rd(5'h10, d); check("R9 set wins", d, 32'h4);
        wr(5'h08, 32'h5);
        @(negedge clk);
        wr(5'h10, 32'h0);
        rd(5'h10, d); check("R9 clear after fix", d, 32'h0);

        // R10 seed pulse
        wr(5'h08, 32'hA);
        check("R10 pulse high", {31'h0, seed_load}, 32'h1);
        @(negedge clk);
        check("R10 pulse one cycle", {31'h0, seed_load}, 32'h0);
        wr(5'h08, 32'hA);
        check("R10 no pulse when held", {31'h0, seed_load}, 32'h0);
        wr(5'h08, 32'h5);
        check("R10 no pulse on disable", {31'h0, seed_load}, 32'h0);
        wr(5'h08, 32'hA);
        check("R10 pulse again", {31'h0, seed_load}, 32'h1);

        // R3 quality masking
        qual_in = 1'b1;
        wr(5'h0C, 32'hA);
        check("R3 qual passes", {31'h0, qual_out}, 32'h1);
        wr(5'h0C, 32'h5);
        check("R3 qual masked", {31'h0, qual_out}, 32'h0);
        qual_in = 1'b0;
        #1; check("R3 qual low input", {31'h0, qual_out}, 32'h0);

        // R4 R5 module lock
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, d); check("R4 write one no effect", d, 32'h1);
        wr(5'h00, 32'h0);
        rd(5'h00, d); check("R4 cleared", d, 32'h0);
        wr(5'h00, 32'h1);
        rd(5'h00, d); check("R4 cannot reopen", d, 32'h0);
        wr(5'h08, 32'h5);
        rd(5'h08, d); check("R5 locked field ignored", d, 32'hA);
        check("R5 mod_en kept", {31'h0, mod_en}, 32'h1);
        wr(5'h0C, 32'hA);
        rd(5'h0C, d); check("R5 conf still writable", d, 32'hA);

        // R6 general lock
        wr(5'h04, 32'h0);
        rd(5'h04, d); check("R6 gen lock cleared", d, 32'h0);
        wr(5'h0C, 32'h5);
        rd(5'h0C, d); check("R6 conf ignored", d, 32'hA);
        check("R6 strict kept", {31'h0, strict_en}, 32'h1);

        summary();
        $finish;
    end
endmodule